// File: doc/BRIEF.md
# Cascadable Nibble Magnitude Comparator Chain

This block compares two unsigned operands one nibble at a time. Each stage compares a 4-bit slice of operand A with the matching slice of operand B. It also takes a three-wire relation (less, equal, greater) from the stage below it. When its own slices differ, the stage reports its own verdict. When the slices are equal, it forwards the verdict from below. Stages are chained from the least significant nibble up to the most significant one, so the top stage gives the answer for the full width.

The top module chains three stages to compare 12-bit operands, split as bits [11:8], [7:4] and [3:0]. The lowest stage is seeded with the relation "equal", so equal operands come out as equal. The whole path is combinational. The stage module can also be used alone in other wide comparators.

Top module: `magCompareChain`

## Requirements
- R1: In a stage, the greater output is 1 when slice A > slice B, or when the slices are equal and the greater cascade input is 1.
- R2: In a stage, the equal output is 1 only when the slices are equal and the equal cascade input is 1.
- R3: In a stage, the less output is 1 when slice A < slice B, or when the slices are equal and the less cascade input is 1.
- R4: When a stage's slices differ, the cascade inputs have no effect. The outputs show only that stage's own relation.
- R5: When a stage's slices are equal, its outputs copy the cascade inputs bit for bit, for any pattern (none set, one set, or several set).
- R6: In the chain, the most significant nibble that differs (nibbles at [11:8], [7:4] and [3:0]) decides outLess or outGreater, whatever the lower nibbles hold.
- R7: The chain reports outEqual=1 with outLess=0 and outGreater=0 exactly when opA equals opB.
- R8: The lowest stage is seeded with equal=1, less=0, greater=0. So operands that differ only in bit 0 still resolve to outLess or outGreater.
- R9: When a stage's cascade input has exactly one bit set, exactly one of its outputs is set. The chain's outputs are therefore always one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 12 | First unsigned operand |
| opB | input | 12 | Second unsigned operand |
| outLess | output | 1 | opA < opB |
| outEqual | output | 1 | opA == opB |
| outGreater | output | 1 | opA > opB |

## Verification
The bench builds the chain with its defaults: a digit width of 4 and three stages. This gives 12-bit operands, a size at which the boundary values (all zeros, all ones, a single differing nibble, a single differing low bit) are easy to reach. It also builds one stage alone with a digit width of 4. That size makes it practical to cover every pair of slices together with all eight cascade patterns, including the ones with no bit set or several bits set. Random 12-bit pairs are added to these cases for the chain.

// File: rtl/magCmpPkg.sv
package magCmpPkg;
  // Relation between two operands, as passed between stages
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } relFlags_t;

  localparam relFlags_t REL_SEED = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
endpackage

// File: rtl/nibbleRelation.sv
// Datapath: MSB-first scan of two slices, yields their relation
module nibbleRelation
  import magCmpPkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] aNib,
  input  logic [DIGIT_W-1:0] bNib,
  output relFlags_t          rel
);
  always_comb begin
    logic seenLt;
    logic seenGt;
    seenLt = 1'b0;
    seenGt = 1'b0;
    for (int i = DIGIT_W - 1; i >= 0; i--) begin
      if (!seenLt && !seenGt) begin
        if (aNib[i] && !bNib[i]) seenGt = 1'b1;
        else if (!aNib[i] && bNib[i]) seenLt = 1'b1;
      end
    end
    rel.lt = seenLt;
    rel.gt = seenGt;
    rel.eq = !seenLt && !seenGt;
    // Scan must agree with arithmetic relation of the slices
    assert_scan_agrees_R4: assert (seenLt == (aNib < bNib) && seenGt == (aNib > bNib))
      else $error("nibble scan disagrees with arithmetic compare");
  end
endmodule

// File: rtl/cascadeMerge.sv
// Control: picks own relation or forwards the lower stage's relation
module cascadeMerge
  import magCmpPkg::*;
(
  input  relFlags_t ownRel,
  input  relFlags_t cascIn,
  output relFlags_t cascOut
);
  always_comb begin
    relFlags_t merged;
    merged.gt = ownRel.gt | (ownRel.eq & cascIn.gt);
    merged.eq = ownRel.eq & cascIn.eq;
    merged.lt = ownRel.lt | (ownRel.eq & cascIn.lt);
    cascOut = merged;
    assert_unequal_blocks_cascade_R4: assert (ownRel.eq || merged == ownRel)
      else $error("cascade input leaked through unequal slices");
    assert_equal_forwards_R5: assert (!ownRel.eq || merged == cascIn)
      else $error("equal slices did not forward cascade input");
    assert_eq_needs_match_R2: assert (!merged.eq || ownRel.eq)
      else $error("equal output without matching slices");
    assert_onehot_kept_R9: assert ($countones(cascIn) != 1 || $countones(merged) == 1)
      else $error("one-hot cascade input gave non-one-hot output");
  end
endmodule

// File: rtl/cmpStage.sv
module cmpStage
  import magCmpPkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] aNib,
  input  logic [DIGIT_W-1:0] bNib,
  input  relFlags_t          cascIn,
  output relFlags_t          cascOut
);
  relFlags_t ownRel;

  nibbleRelation #(.DIGIT_W(DIGIT_W)) uRel (
    .aNib(aNib),
    .bNib(bNib),
    .rel (ownRel)
  );

  cascadeMerge uMerge (
    .ownRel (ownRel),
    .cascIn (cascIn),
    .cascOut(cascOut)
  );
endmodule

// File: rtl/magCompareChain.sv
module magCompareChain
  import magCmpPkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int NUM_STAGES = 3,
  localparam int OP_W      = DIGIT_W * NUM_STAGES
) (
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic            outLess,
  output logic            outEqual,
  output logic            outGreater
);
  relFlags_t chainRel [NUM_STAGES+1];

  assign chainRel[0] = REL_SEED;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : gStage
    cmpStage #(.DIGIT_W(DIGIT_W)) uStage (
      .aNib   (opA[s*DIGIT_W +: DIGIT_W]),
      .bNib   (opB[s*DIGIT_W +: DIGIT_W]),
      .cascIn (chainRel[s]),
      .cascOut(chainRel[s+1])
    );
  end

  assign outLess    = chainRel[NUM_STAGES].lt;
  assign outEqual   = chainRel[NUM_STAGES].eq;
  assign outGreater = chainRel[NUM_STAGES].gt;
endmodule

// File: tb/sim_magCompareChain.sv
module sim_magCompareChain;
  import magCmpPkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DIGIT_W    = 4;
  localparam int NUM_STAGES = 3;
  localparam int OP_W       = DIGIT_W * NUM_STAGES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [OP_W-1:0]    opA = '0;
  logic [OP_W-1:0]    opB = '0;
  logic               outLess, outEqual, outGreater;
  logic [DIGIT_W-1:0] nibA = '0;
  logic [DIGIT_W-1:0] nibB = '0;
  relFlags_t          cin  = '0;
  relFlags_t          sOut;

  magCompareChain #(.DIGIT_W(DIGIT_W), .NUM_STAGES(NUM_STAGES)) u0 (
    .opA(opA), .opB(opB),
    .outLess(outLess), .outEqual(outEqual), .outGreater(outGreater)
  );

  cmpStage #(.DIGIT_W(DIGIT_W)) u1 (
    .aNib(nibA), .bNib(nibB), .cascIn(cin), .cascOut(sOut)
  );

  typedef struct {
    bit         isStage;
    logic [2:0] expRel;
    string      tag;
  } sbItem_t;

  sbItem_t sbq[$];
  int  checks = 0;
  int  fails  = 0;
  bit  allDone = 0;

  // Driver: chain operands, expected {lt,eq,gt}
  task automatic pushChain(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input string tag);
    sbItem_t it;
    @(posedge clk);
    opA <= a;
    opB <= b;
    it.isStage = 1'b0;
    it.expRel  = {a < b, a == b, a > b};
    it.tag     = tag;
    sbq.push_back(it);
  endtask

  // Driver: single stage, expected from R1/R2/R3 rules
  task automatic pushStage(input logic [DIGIT_W-1:0] a, input logic [DIGIT_W-1:0] b,
                           input logic [2:0] c);
    sbItem_t it;
    logic eqN;
    @(posedge clk);
    nibA <= a;
    nibB <= b;
    cin  <= c;
    eqN = (a == b);
    it.isStage = 1'b1;
    it.expRel  = {(a < b) | (eqN & c[2]), eqN & c[1], (a > b) | (eqN & c[0])};
    if (a > b)                 it.tag = "R1,R4";
    else if (a < b)            it.tag = "R3,R4";
    else if ($countones(c) == 1) it.tag = "R2,R5,R9";
    else                       it.tag = "R5";
    sbq.push_back(it);
  endtask

  // Monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sbItem_t it;
      logic [2:0] got;
      it  = sbq.pop_front();
      got = it.isStage ? sOut : {outLess, outEqual, outGreater};
      checks++;
      if (got !== it.expRel) begin
        fails++;
        $display("FAIL %s: %s got lt/eq/gt=%b expected %b", it.tag,
                 it.isStage ? "stage" : "chain", got, it.expRel);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state operands: zeros compare equal
    pushChain('0, '0, "R7");
    // Exhaustive single stage, all cascade patterns
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 8; c++)
          pushStage(a[3:0], b[3:0], c[2:0]);
    // Chain boundaries
    pushChain(12'h000, 12'hFFF, "R6,R9");
    pushChain(12'hFFF, 12'h000, "R6,R9");
    pushChain(12'hFFF, 12'hFFF, "R7");
    pushChain(12'h100, 12'h0FF, "R6");
    pushChain(12'h0FF, 12'h100, "R6");
    pushChain(12'h5A0, 12'h5AF, "R6");
    pushChain(12'h5B0, 12'h5AF, "R6");
    pushChain(12'h800, 12'h7FF, "R6");
    for (int k = 0; k < 12; k++) begin
      logic [OP_W-1:0] v;
      v = 12'hA5C ^ (12'h1 << k);
      pushChain(v, 12'hA5C, "R6,R9");
    end
    // Differ only in bit 0
    pushChain(12'h000, 12'h001, "R8");
    pushChain(12'h001, 12'h000, "R8");
    pushChain(12'hFFE, 12'hFFF, "R8");
    pushChain(12'h3C7, 12'h3C6, "R8");
    // Random pairs
    for (int r = 0; r < 300; r++) begin
      logic [OP_W-1:0] ra, rb;
      ra = OP_W'($urandom);
      rb = (r % 5 == 0) ? ra : OP_W'($urandom);
      if (r % 7 == 0) rb = ra ^ 12'h001;
      pushChain(ra, rb, (ra == rb) ? "R7" : "R6,R9");
    end
    repeat (3) @(posedge clk);
    allDone = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!allDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule